// File: doc/BRIEF.md
# Eight-Bit Posit Adder (zero exponent bits)

This block adds two 8-bit posit numbers that carry no exponent field and returns their 8-bit posit sum. It is pure combinational logic: the sum follows the operands with no clock, register or handshake in between, so it can sit inside a larger datapath stage.

The operation runs in four steps. First, each operand is unpacked into a sign, a scale and a significand with a hidden leading one. Second, the operand with the smaller magnitude is shifted right by the scale difference and added to, or subtracted from, the larger one. Third, the exact result is normalised. Finally, it is packed back into posit form with round-to-nearest-even on the encoded bit string. Results never leave the finite range: large sums clamp to the largest posit, and a nonzero sum is never returned as zero.

Top module: `posit_adder`

## Requirements
- R1: When either operand is the not-a-real word 8'h80, the sum is 8'h80.
- R2: When one operand is 8'h00 (zero), the sum equals the other operand unchanged, and 0 + 0 gives 8'h00.
- R3: The sum of a value and its negation (words w and -w, two's complement) is 8'h00.
- R4: A negative operand is read by two's complementing the whole word before reading the regime. A run of m ones gives scale m-1, and a run of m zeros gives scale -m. The bits after the terminating bit are a fraction with a hidden 1. A sum that is exactly representable is returned exactly, with bit 7 set if and only if the sum is negative.
- R5: An inexact sum rounds to the nearer neighbouring posit. An exact tie goes to the neighbour whose bit 0 is 0.
- R6: A sum whose magnitude is 64 or more returns 8'h7F (positive) or 8'h81 (negative).
- R7: A nonzero sum never yields 8'h00 or 8'h80. A magnitude at or below 2^-6 returns 8'h01 (positive) or 8'h FF (negative).
- R8: The sum depends only on the present operands and settles without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First posit operand |
| b_i | input | 8 | Second posit operand |
| sum_o | output | 8 | Posit sum of a_i and b_i |

## Verification
Every one of the 65536 operand pairs is applied, and each result is compared with a model that converts both words to exact scaled integers, adds them, and searches a table of all positive posit values for the nearest word. Each pair is filed under the requirement it exercises: not-a-real inputs, a zero operand, exact cancellation, clamping at the top, the smallest magnitude, exactly representable sums, and rounded sums, including the ties that separate even from odd words. A separate check changes the operands between clock edges and reads the sum before the next edge, which shows that the block holds no state.

// File: rtl/padd_pkg.sv
package padd_pkg;

   // fraction bits available at the shortest regime
   function automatic int frac_w(input int n);
      return n - 3;
   endfunction

   // signed scale width, wide enough for every intermediate scale
   function automatic int scale_w(input int n);
      return $clog2(n) + 3;
   endfunction

   // largest possible scale difference between two operands
   function automatic int shift_max(input int n);
      return 2 * (n - 2);
   endfunction

   // exact alignment field: carry bit, significand, full shift span
   function automatic int acc_w(input int n);
      return frac_w(n) + 2 + shift_max(n);
   endfunction

   // regime run counter width
   function automatic int cnt_w(input int n);
      return $clog2(n) + 1;
   endfunction

endpackage

// File: rtl/padd_decode.sv
module padd_decode #(
   parameter int N = 8
) (
   input  logic [N-1:0]                            word_i,
   output logic                                    nar_o,
   output logic                                    zero_o,
   output logic                                    neg_o,
   output logic signed [padd_pkg::scale_w(N)-1:0]  scale_o,
   output logic [padd_pkg::frac_w(N):0]            sig_o
);
   localparam int FW = padd_pkg::frac_w(N);
   localparam int SW = padd_pkg::scale_w(N);
   localparam int LW = padd_pkg::cnt_w(N);

   logic [N-1:0]         mag;
   logic [N-2:0]         body;
   logic [LW-1:0]        run;
   logic                 live;
   logic signed [SW-1:0] run_s;
   logic [FW-1:0]        frac;

   always_comb begin
      nar_o  = (word_i == {1'b1, {(N-1){1'b0}}});
      zero_o = (word_i == '0);
      neg_o  = word_i[N-1];
      mag    = neg_o ? -word_i : word_i;
      body   = mag[N-2:0];
      run    = '0;
      live   = 1'b1;
      for (int i = N-2; i >= 0; i--) begin
         if (live && (body[i] == body[N-2])) run = run + LW'(1);
         else                                live = 1'b0;
      end
      run_s   = SW'(run);
      scale_o = body[N-2] ? (run_s - SW'(1)) : -run_s;
      frac    = FW'((body << (run + LW'(1))) >> (N-1-FW));
      sig_o   = {1'b1, frac};
      // scale of an ordinary word always lies within the regime span (R4)
      if (!nar_o && !zero_o) begin
         assert_dec_range_R4: assert (scale_o <= SW'(N-2) && scale_o >= -SW'(N-2))
            else $error("decoded scale out of range");
      end
   end
endmodule

// File: rtl/padd_align_add.sv
module padd_align_add #(
   parameter int N = 8
) (
   input  logic                                    a_neg_i,
   input  logic signed [padd_pkg::scale_w(N)-1:0]  a_scale_i,
   input  logic [padd_pkg::frac_w(N):0]            a_sig_i,
   input  logic                                    b_neg_i,
   input  logic signed [padd_pkg::scale_w(N)-1:0]  b_scale_i,
   input  logic [padd_pkg::frac_w(N):0]            b_sig_i,
   output logic                                    res_neg_o,
   output logic                                    res_zero_o,
   output logic signed [padd_pkg::scale_w(N)-1:0]  res_scale_o,
   output logic [padd_pkg::acc_w(N)-2:0]           res_frac_o
);
   localparam int FW = padd_pkg::frac_w(N);
   localparam int SW = padd_pkg::scale_w(N);
   localparam int DM = padd_pkg::shift_max(N);
   localparam int AW = padd_pkg::acc_w(N);
   localparam int PW = $clog2(AW);

   logic                 a_big;
   logic                 differ;
   logic signed [SW-1:0] sc_big, sc_small, gap;
   logic [FW:0]          sg_big, sg_small;
   logic [AW-1:0]        wide_big, wide_small, total;
   logic [PW-1:0]        lead;
   logic                 found;

   always_comb begin
      a_big    = (a_scale_i > b_scale_i) ||
                 ((a_scale_i == b_scale_i) && (a_sig_i >= b_sig_i));
      sc_big   = a_big ? a_scale_i : b_scale_i;
      sc_small = a_big ? b_scale_i : a_scale_i;
      sg_big   = a_big ? a_sig_i   : b_sig_i;
      sg_small = a_big ? b_sig_i   : a_sig_i;
      gap      = sc_big - sc_small;
      differ   = a_neg_i ^ b_neg_i;
      wide_big   = {1'b0, sg_big, {DM{1'b0}}};
      wide_small = {1'b0, sg_small, {DM{1'b0}}} >> unsigned'(gap);
      total      = differ ? (wide_big - wide_small) : (wide_big + wide_small);
      res_neg_o  = a_big ? a_neg_i : b_neg_i;
      res_zero_o = (total == '0);
      lead  = '0;
      found = 1'b0;
      for (int i = AW-1; i >= 0; i--) begin
         if (!found && total[i]) begin
            lead  = PW'(i);
            found = 1'b1;
         end
      end
      res_frac_o  = (AW-1)'(total << (PW'(AW-1) - lead));
      res_scale_o = sc_big + $signed(SW'(lead)) - SW'(FW + DM);
      // magnitude ordering keeps the exact sum free of wrap-around (R4, R3)
      assert_no_wrap_R4: assert (differ ? (total <= wide_big) : (total >= wide_big))
         else $error("aligned sum wrapped");
   end
endmodule

// File: rtl/padd_encode.sv
module padd_encode #(
   parameter int N = 8
) (
   input  logic                                    neg_i,
   input  logic                                    zero_i,
   input  logic signed [padd_pkg::scale_w(N)-1:0]  scale_i,
   input  logic [padd_pkg::acc_w(N)-2:0]           frac_i,
   output logic [N-1:0]                            word_o
);
   localparam int SW = padd_pkg::scale_w(N);
   localparam int AW = padd_pkg::acc_w(N);
   localparam int RW = N + 1;
   localparam int XW = RW + AW - 1;
   localparam logic [N-1:0] MAXPOS = {1'b0, {(N-1){1'b1}}};
   localparam logic [N-1:0] NARW   = {1'b1, {(N-1){1'b0}}};

   int            k_val;
   int            r_len;
   logic [RW-1:0] rpat;
   logic [XW-1:0] xstr;
   logic [N-2:0]  kept, mag;
   logic          guard, sticky, bump;

   always_comb begin
      k_val = int'(scale_i);
      if (!scale_i[SW-1]) begin
         r_len = k_val + 2;
         rpat  = (~({RW{1'b1}} << (k_val + 1))) << 1;
      end else begin
         r_len = 1 - k_val;
         rpat  = RW'(1);
      end
      xstr   = {rpat, frac_i} << (RW - r_len);
      kept   = xstr[XW-1 -: N-1];
      guard  = xstr[XW-N];
      sticky = |xstr[XW-N-1:0];
      bump   = guard && (sticky || kept[0]);
      if (scale_i >= SW'(N-2))       mag = '1;
      else if (scale_i < -SW'(N-2))  mag = (N-1)'(1);
      else                           mag = kept + {{(N-2){1'b0}}, bump};
      if (zero_i)     word_o = '0;
      else if (neg_i) word_o = -{1'b0, mag};
      else            word_o = {1'b0, mag};

      assert_never_vanish_R7: assert (zero_i || (word_o != '0 && word_o != NARW))
         else $error("nonzero sum encoded as zero or NaR");
      assert_sign_bit_R4: assert (zero_i || (word_o[N-1] == neg_i))
         else $error("sign bit disagrees with sum sign");
      if (!zero_i && scale_i >= SW'(N-2)) begin
         assert_clamp_top_R6: assert ((neg_i ? -word_o : word_o) == MAXPOS)
            else $error("large sum not clamped");
      end
   end
endmodule

// File: rtl/posit_adder.sv
module posit_adder #(
   parameter int N  = 8,
   parameter int ES = 0
) (
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [N-1:0] sum_o
);
   localparam int FW = padd_pkg::frac_w(N);
   localparam int SW = padd_pkg::scale_w(N);
   localparam int AW = padd_pkg::acc_w(N);
   localparam logic [N-1:0] NARW = {1'b1, {(N-1){1'b0}}};

   if (N < 5) begin : g_bad_width
      $error("posit_adder: N must be at least 5");
   end
   if (ES != 0) begin : g_bad_es
      $error("posit_adder: only zero exponent bits supported");
   end

   logic [N-1:0]         op_w     [2];
   logic                 op_nar   [2];
   logic                 op_zero  [2];
   logic                 op_neg   [2];
   logic signed [SW-1:0] op_scale [2];
   logic [FW:0]          op_sig   [2];

   assign op_w[0] = a_i;
   assign op_w[1] = b_i;

   for (genvar g = 0; g < 2; g++) begin : g_dec
      padd_decode #(.N(N)) u_dec (
         .word_i  (op_w[g]),
         .nar_o   (op_nar[g]),
         .zero_o  (op_zero[g]),
         .neg_o   (op_neg[g]),
         .scale_o (op_scale[g]),
         .sig_o   (op_sig[g])
      );
   end

   logic                 res_neg, res_zero;
   logic signed [SW-1:0] res_scale;
   logic [AW-2:0]        res_frac;
   logic [N-1:0]         enc_word;

   padd_align_add #(.N(N)) u_add (
      .a_neg_i     (op_neg[0]),
      .a_scale_i   (op_scale[0]),
      .a_sig_i     (op_sig[0]),
      .b_neg_i     (op_neg[1]),
      .b_scale_i   (op_scale[1]),
      .b_sig_i     (op_sig[1]),
      .res_neg_o   (res_neg),
      .res_zero_o  (res_zero),
      .res_scale_o (res_scale),
      .res_frac_o  (res_frac)
   );

   padd_encode #(.N(N)) u_enc (
      .neg_i   (res_neg),
      .zero_i  (res_zero),
      .scale_i (res_scale),
      .frac_i  (res_frac),
      .word_o  (enc_word)
   );

   always_comb begin
      if (op_nar[0] || op_nar[1]) sum_o = NARW;
      else if (op_zero[0])        sum_o = b_i;
      else if (op_zero[1])        sum_o = a_i;
      else                        sum_o = enc_word;
   end
endmodule

// File: tb/posit_adder_tb_top.sv
module posit_adder_tb_top;
   localparam time HALF = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a_r = 8'h00;
   logic [7:0] b_r = 8'h00;
   logic [7:0] sum_w;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done = 1'b0;
   longint     pos_val [128];

   always #(HALF) clk = ~clk;

   posit_adder dut_i (.a_i(a_r), .b_i(b_r), .sum_o(sum_w));

   // value of a posit word in units of 2^-11, behavioural reading
   function automatic longint dec_val(input logic [7:0] w);
      logic [7:0] m;
      int run, k, nf;
      longint frac, v;
      bit first;
      m = w[7] ? 8'(-w) : w;
      first = m[6];
      run = 0;
      for (int i = 6; i >= 0; i--) begin
         if (m[i] != first) break;
         run++;
      end
      k  = first ? run - 1 : -run;
      nf = 6 - run;
      if (nf < 0) nf = 0;
      frac = longint'(m) & ((longint'(1) << nf) - 1);
      v = ((longint'(1) << nf) | frac) << (k + 11 - nf);
      return w[7] ? -v : v;
   endfunction

   function automatic logic [7:0] ref_sum(input logic [7:0] a, input logic [7:0] b,
                                          output string tag);
      longint s, mg, lo, hi;
      int r;
      if (a == 8'h80 || b == 8'h80) begin tag = "R1"; return 8'h80; end
      if (a == 8'h00) begin tag = "R2"; return b; end
      if (b == 8'h00) begin tag = "R2"; return a; end
      s = dec_val(a) + dec_val(b);
      if (s == 0) begin tag = "R3"; return 8'h00; end
      mg = (s < 0) ? -s : s;
      r = 0;
      if (mg >= pos_val[127]) begin tag = "R6"; r = 127; end
      else if (mg <= pos_val[1]) begin tag = "R7"; r = 1; end
      else begin
         for (int p = 1; p < 127; p++) begin
            lo = pos_val[p];
            hi = pos_val[p+1];
            if (mg >= lo && mg < hi) begin
               if (mg == lo) begin tag = "R4"; r = p; end
               else begin
                  tag = "R5";
                  if (2*mg < lo + hi)      r = p;
                  else if (2*mg > lo + hi) r = p + 1;
                  else                     r = (p % 2 == 0) ? p : p + 1;
               end
            end
         end
      end
      return (s < 0) ? 8'(-r) : 8'(r);
   endfunction

   task automatic compare(input string tag, input logic [7:0] exp);
      n_cmp++;
      if (sum_w !== exp) begin
         n_bad++;
         $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a_r, b_r, sum_w, exp);
      end
   endtask

   task automatic one_pair(input logic [7:0] a, input logic [7:0] b);
      string tag;
      logic [7:0] exp;
      @(posedge clk);
      a_r = a;
      b_r = b;
      exp = ref_sum(a, b, tag);
      @(negedge clk);
      compare(tag, exp);
   endtask

   initial begin
      string tg;
      logic [7:0] ex;
      for (int p = 1; p < 128; p++) pos_val[p] = dec_val(8'(p));
      pos_val[0] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R2", 8'h00);                     // idle state: 0 + 0
      rst_n = 1'b1;
      // directed corner cases
      one_pair(8'h80, 8'h40);                   // R1 NaR wins
      one_pair(8'h00, 8'h5A);                   // R2 zero operand
      one_pair(8'h37, 8'hC9);                   // R3 cancellation
      one_pair(8'h40, 8'h40);                   // R4 1 + 1 = 2
      one_pair(8'h40, 8'h01);                   // R5 tie to even
      one_pair(8'h7F, 8'h7F);                   // R6 clamp high
      one_pair(8'h81, 8'h81);                   // R6 clamp negative
      one_pair(8'h02, 8'hFF);                   // R7 smallest magnitude
      // R8: operands change between edges, sum is read before the next edge
      #3ns;
      a_r = 8'h40;
      b_r = 8'h40;
      ex = ref_sum(8'h40, 8'h40, tg);
      #2ns;
      compare("R8", ex);
      a_r = 8'hC0;
      ex = ref_sum(8'hC0, 8'h40, tg);
      #2ns;
      compare("R8", ex);
      // exhaustive sweep over every operand pair
      for (int ai = 0; ai < 256; ai++) begin
         for (int bi = 0; bi < 256; bi++) begin
            one_pair(8'(ai), 8'(bi));
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(150000 * 2 * HALF);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule